// File: doc/BRIEF.md
# Serial Byte Exchanger, Target Side

This block is the target end of a four-wire serial link in the style of SPI. A remote controller drives the shift clock and, when the select input is in use, an active-low select line. Each rising edge of that clock samples one incoming bit. After each falling edge the block presents its next outgoing bit. Outgoing and incoming bits move through a single shift buffer, so every byte exchange is full duplex.

On the host side, a data register holds the byte queued for the next exchange. When an exchange finishes, the received byte replaces it in the same register. Two flags are sticky: a completion flag, raised with a one-cycle interrupt pulse, and a collision flag. The collision flag is raised when the host tries to write while a byte is half-way through the buffer.

The serial inputs come from another clock domain. They pass through a two-stage synchronizer, and edges are found in the system clock domain. The remote clock must therefore stay well below the system clock.

Top module: `spi_tgt`

## Requirements
- R1: The block counts bits and drives the serial output only when `en_i` is 1 and `mode_i` equals 2'b11. Otherwise the clock is ignored, no completion occurs and `sdo_oe_o` is 0.
- R2: Each rising edge of the synchronized shift clock samples one bit. The outgoing bit changes only after a falling edge. The first outgoing bit is on `sdo_o` as soon as a byte has been loaded.
- R3: With `lsb_first_i` = 0, the byte is sent and received most significant bit first. The controller receives the loaded data byte, and the block receives the controller's byte.
- R4: On the eighth rising edge, the received byte is written into the data register and `done_o` is set. `irq_o` pulses high for exactly one cycle.
- R5: With `lsb_first_i` = 1, both directions go least significant bit first.
- R6: A host write while one to seven bits of a byte have arrived sets `wcol_o`. The write changes neither `rdata_o` nor the byte being shifted out.
- R7: `done_o` stays set until `clr_done_i` is pulsed, and `wcol_o` stays set until `clr_wcol_i` is pulsed. While `wcol_o` is set, host writes are ignored.
- R8: With `cs_use_i` = 1 and `ss_ni` high, any partial byte is discarded, the bit count returns to zero, `sdo_oe_o` is 0 and clock edges are ignored.
- R9: With `cs_use_i` = 0, the level of `ss_ni` has no effect.
- R10: A host write accepted while idle loads the data register, which reads back on `rdata_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Interface enable |
| mode_i | input | 2 | Operating mode; 2'b11 selects target operation |
| cs_use_i | input | 1 | 1 = the select line gates transfers |
| lsb_first_i | input | 1 | Bit order: 1 = least significant bit first |
| wr_i | input | 1 | Host write strobe for the data register |
| wdata_i | input | 8 | Host write data |
| clr_wcol_i | input | 1 | Clears the collision flag |
| clr_done_i | input | 1 | Clears the completion flag |
| rdata_o | output | 8 | Data register contents |
| wcol_o | output | 1 | Sticky write-collision flag |
| done_o | output | 1 | Sticky transfer-complete flag |
| irq_o | output | 1 | One-cycle completion interrupt |
| sck_i | input | 1 | Shift clock from the controller |
| ss_ni | input | 1 | Active-low select from the controller |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |

## Verification
The bench writes in the middle of a byte. A design that accepted that write would corrupt the rest of the outgoing byte and overwrite the data register. The bench also writes again before clearing the collision flag, to catch a flag that is not sticky or that lets writes through.

It drops the select line after three bits and then writes and runs a full byte. A counter that survived the abort would finish early, with a shifted result and a spurious collision.

Bit order is tested in both directions with asymmetric patterns, so mirrored or off-by-one shifting shows up. Exchanges with the block disabled, in the wrong mode, or with the select line high must leave the completion flag clear and the output undriven.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  typedef logic [1:0] mode_t;
  localparam mode_t MODE_TARGET = 2'b11;
  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else         stage_q[g] <= stage_d[g];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_tgt_rstsync.sv
module spi_tgt_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift #(
  parameter int unsigned DW = 8,
  localparam int unsigned CW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          cs_use_i,
  input  logic          lsb_first_i,
  input  logic          sck_s_i,
  input  logic          ss_s_i,
  input  logic          sdi_s_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic          busy_o,
  output logic          complete_o,
  output logic [DW-1:0] rx_byte_o
);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sck_prev_q, sck_prev_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] buf_q, buf_d;
  logic          smp_q, smp_d;
  logic          run, rise, fall;

  assign run  = active_i && (!cs_use_i || !ss_s_i);
  assign rise = sck_s_i && !sck_prev_q;
  assign fall = !sck_s_i && sck_prev_q;

  always_comb begin
    sck_prev_d = sck_s_i;
    cnt_d      = cnt_q;
    buf_d      = buf_q;
    smp_d      = smp_q;
    complete_o = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (rise) begin
      smp_d = sdi_s_i;
      if (cnt_q == LAST) begin
        cnt_d      = '0;
        complete_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (fall && cnt_q != '0) begin
      if (lsb_first_i) buf_d = {smp_q, buf_q[DW-1:1]};
      else             buf_d = {buf_q[DW-2:0], smp_q};
    end
    if (load_i) buf_d = load_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      cnt_q      <= '0;
      buf_q      <= '0;
      smp_q      <= 1'b0;
    end else begin
      sck_prev_q <= sck_prev_d;
      cnt_q      <= cnt_d;
      buf_q      <= buf_d;
      smp_q      <= smp_d;
    end
  end

  assign rx_byte_o = lsb_first_i ? {sdi_s_i, buf_q[DW-1:1]} : {buf_q[DW-2:0], sdi_s_i};
  assign busy_o    = (cnt_q != '0);
  assign sdo_oe_o  = run;
  assign sdo_o     = run && (lsb_first_i ? buf_q[0] : buf_q[DW-1]);

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0)); // R1
  AST_ABORT_ON_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_use_i && ss_s_i) |=> (cnt_q == '0)); // R8
  AST_SHIFT_ONLY_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(fall && busy_o)) |=> $stable(buf_q)); // R2
endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_wcol_i,
  input  logic          clr_done_i,
  input  logic          busy_i,
  input  logic          complete_i,
  input  logic [DW-1:0] rx_byte_i,
  output logic [DW-1:0] rdata_o,
  output logic          wcol_o,
  output logic          done_o,
  output logic          irq_o,
  output logic          load_o,
  output logic [DW-1:0] load_data_o
);
  logic [DW-1:0] data_q, data_d;
  logic          wcol_q, wcol_d;
  logic          done_q, done_d;
  logic          irq_q, irq_d;
  logic          accept, reject;

  assign accept = wr_i && !busy_i && !wcol_q;
  assign reject = wr_i && !accept;

  always_comb begin
    data_d = data_q;
    if (complete_i)  data_d = rx_byte_i;
    else if (accept) data_d = wdata_i;
    wcol_d = wcol_q;
    if (reject)          wcol_d = 1'b1;
    else if (clr_wcol_i) wcol_d = 1'b0;
    done_d = done_q;
    if (complete_i)      done_d = 1'b1;
    else if (clr_done_i) done_d = 1'b0;
    irq_d = complete_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      wcol_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      wcol_q <= wcol_d;
      done_q <= done_d;
      irq_q  <= irq_d;
    end
  end

  assign rdata_o     = data_q;
  assign wcol_o      = wcol_q;
  assign done_o      = done_q;
  assign irq_o       = irq_q;
  assign load_o      = accept;
  assign load_data_o = wdata_i;

  AST_WCOL_ON_BUSY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_i) |=> wcol_q); // R6
  AST_REJECT_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (busy_i || wcol_q) && !complete_i) |=> $stable(data_q)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_done_i) |=> done_q); // R7
  AST_IRQ_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> done_q); // R4
  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q); // R4
endmodule

// File: rtl/spi_tgt.sv
module spi_tgt
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    mode_i,
  input  logic          cs_use_i,
  input  logic          lsb_first_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_wcol_i,
  input  logic          clr_done_i,
  output logic [DW-1:0] rdata_o,
  output logic          wcol_o,
  output logic          done_o,
  output logic          irq_o,
  input  logic          sck_i,
  input  logic          ss_ni,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  logic          rst_n;
  logic [2:0]    pins_s;
  logic          active;
  logic          busy, complete, load;
  logic [DW-1:0] rx_byte, load_data;

  spi_tgt_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n),
    .d_i  ({sdi_i, ss_ni, sck_i}),
    .q_o  (pins_s)
  );

  assign active = en_i && (mode_t'(mode_i) == MODE_TARGET);

  spi_tgt_shift #(.DW(DW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .active_i   (active),
    .cs_use_i   (cs_use_i),
    .lsb_first_i(lsb_first_i),
    .sck_s_i    (pins_s[0]),
    .ss_s_i     (pins_s[1]),
    .sdi_s_i    (pins_s[2]),
    .load_i     (load),
    .load_data_i(load_data),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .busy_o     (busy),
    .complete_o (complete),
    .rx_byte_o  (rx_byte)
  );

  spi_tgt_regs #(.DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .clr_wcol_i (clr_wcol_i),
    .clr_done_i (clr_done_i),
    .busy_i     (busy),
    .complete_i (complete),
    .rx_byte_i  (rx_byte),
    .rdata_o    (rdata_o),
    .wcol_o     (wcol_o),
    .done_o     (done_o),
    .irq_o      (irq_o),
    .load_o     (load),
    .load_data_o(load_data)
  );

  AST_OE_ONLY_WHEN_ON: assert property (@(posedge clk_i) disable iff (!rst_n)
    sdo_oe_o |-> (en_i && mode_i == 2'b11)); // R1
endmodule

// File: tb/tb_spi_tgt.sv
module tb_spi_tgt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       cs_use = 1'b0, lsb = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       clr_wcol = 1'b0, clr_done = 1'b0;
  logic [7:0] rdata;
  logic       wcol, done, irq;
  logic       sck = 1'b0, ss_n = 1'b1, sdi = 1'b0;
  logic       sdo, sdo_oe;

  int nchk = 0, nfail = 0, irq_cnt = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got;

  always #2.5 clk = ~clk;

  spi_tgt dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .cs_use_i(cs_use), .lsb_first_i(lsb), .wr_i(wr), .wdata_i(wdata),
    .clr_wcol_i(clr_wcol), .clr_done_i(clr_done), .rdata_o(rdata),
    .wcol_o(wcol), .done_o(done), .irq_o(irq), .sck_i(sck), .ss_ni(ss_n),
    .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // Monitor: each completion pulse pops one expected byte
  always @(negedge clk) begin
    if (rst_n && irq) begin
      irq_cnt++;
      if (exp_q.size() == 0) chk("R4 unexpected irq", 8'h01, 8'h00);
      else chk("R4 received byte", rdata, exp_q.pop_front());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
    idle(2);
  endtask

  task automatic pulse_clr(input bit which_done);
    @(negedge clk);
    if (which_done) clr_done = 1'b1; else clr_wcol = 1'b1;
    @(negedge clk); clr_done = 1'b0; clr_wcol = 1'b0;
    idle(2);
  endtask

  // Controller side: bits [from, upto) of byte m in the current order
  task automatic shift_bits(input logic [7:0] m, input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      int idx = lsb ? i : 7 - i;
      sdi = m[idx];
      idle(8);
      got[idx] = sdo;
      sck = 1'b1;
      idle(8);
      sck = 1'b0;
      idle(8);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(6);
    chk("R10 reset rdata", rdata, 8'h00);
    chk("R7 reset flags", {5'b0, wcol, done, irq}, 8'h00);
    chk("R1 reset oe", {7'b0, sdo_oe}, 8'h00);

    // R1: disabled, then wrong mode
    mode = 2'b11; en = 1'b0;
    host_wr(8'hA5);
    chk("R10 idle write", rdata, 8'hA5);
    shift_bits(8'h0F, 0, 8);
    chk("R1 disabled no done", {7'b0, done}, 8'h00);
    chk("R1 disabled oe", {7'b0, sdo_oe}, 8'h00);
    en = 1'b1; mode = 2'b10;
    idle(4);
    shift_bits(8'hF0, 0, 8);
    chk("R1 wrong mode no done", {7'b0, done}, 8'h00);
    chk("R1 wrong mode oe", {7'b0, sdo_oe}, 8'h00);

    // R3/R4/R9: MSB first, select unused while ss_n stays high
    mode = 2'b11;
    idle(4);
    chk("R9 oe with ss_n high", {7'b0, sdo_oe}, 8'h01);
    host_wr(8'h3C);
    chk("R10 load", rdata, 8'h3C);
    exp_q.push_back(8'h96);
    shift_bits(8'h96, 0, 8);
    chk("R3 controller got", got, 8'h3C);
    chk("R4 data reg", rdata, 8'h96);
    chk("R4 done set", {7'b0, done}, 8'h01);
    chk("R4 one pulse", 8'(irq_cnt), 8'd1);
    idle(20);
    chk("R7 done sticky", {7'b0, done}, 8'h01);
    pulse_clr(1'b1);
    chk("R7 done cleared", {7'b0, done}, 8'h00);

    // R5: LSB first
    lsb = 1'b1;
    host_wr(8'hB1);
    exp_q.push_back(8'h4E);
    shift_bits(8'h4E, 0, 8);
    chk("R5 controller got", got, 8'hB1);
    chk("R5 data reg", rdata, 8'h4E);

    // R6/R7: collision mid-byte
    lsb = 1'b0;
    host_wr(8'h5A);
    shift_bits(8'hC6, 0, 3);
    host_wr(8'hFF);
    chk("R6 wcol set", {7'b0, wcol}, 8'h01);
    chk("R6 data kept", rdata, 8'h5A);
    exp_q.push_back(8'hC6);
    shift_bits(8'hC6, 3, 8);
    chk("R6 outgoing kept", got, 8'h5A);
    host_wr(8'h11);
    chk("R7 write ignored while wcol", rdata, 8'hC6);
    chk("R7 wcol sticky", {7'b0, wcol}, 8'h01);
    pulse_clr(1'b0);
    chk("R7 wcol cleared", {7'b0, wcol}, 8'h00);
    host_wr(8'h11);
    chk("R10 write after clear", rdata, 8'h11);

    // R8: select line in use
    pulse_clr(1'b1);
    cs_use = 1'b1; ss_n = 1'b1;
    idle(4);
    chk("R8 oe off deselected", {7'b0, sdo_oe}, 8'h00);
    shift_bits(8'h77, 0, 8);
    chk("R8 clock ignored", {7'b0, done}, 8'h00);
    ss_n = 1'b0; idle(4);
    chk("R8 oe on selected", {7'b0, sdo_oe}, 8'h01);
    host_wr(8'hC3);
    shift_bits(8'hFF, 0, 3);
    ss_n = 1'b1; idle(4);
    chk("R8 oe off after abort", {7'b0, sdo_oe}, 8'h00);
    host_wr(8'h24);
    chk("R8 write accepted after abort", rdata, 8'h24);
    chk("R8 no collision", {7'b0, wcol}, 8'h00);
    ss_n = 1'b0; idle(4);
    exp_q.push_back(8'h81);
    shift_bits(8'h81, 0, 8);
    chk("R8 full byte after abort", got, 8'h24);
    chk("R8 data reg", rdata, 8'h81);

    idle(10);
    chk("R4 all completions seen", 8'(exp_q.size()), 8'd0);
    chk("R4 pulse count", 8'(irq_cnt), 8'd4);
    finish_run();
  end
endmodule